// File: doc/BRIEF.md
# Mode-Selected Wiper Update Controller

This block owns the 7-bit wiper code of a digital potentiometer. Two mode bits choose where the code comes from. In direct mode only the host sets it. In table mode it follows a lookup-table byte. In offset mode it follows the sum of an initial-value register and the table byte, where the table byte is read as a signed offset. A new table result is applied only on the pulse that marks the end of a conversion.

After reset the block copies the initial value into the wiper. A manual-override bit and a standby bit can each stop automatic loading. The table memory, the temperature sensor and the nonvolatile storage of the initial value are outside this block. They supply the table byte, the initial-value byte and the conversion-done pulse.

Top module: `wiper_update_ctrl`

## Requirements
- R1: Mode decode: `mode_update`=0 selects direct mode whatever `mode_adder` is. `mode_update`=1 with `mode_adder`=0 selects table mode. `mode_update`=1 with `mode_adder`=1 selects offset mode.
- R2: On the first clock after reset is released, the wiper takes the initial value `init_val`. If `init_val` is above 7Fh, the wiper takes 7Fh instead.
- R3: In direct mode, a host write to address 00h sets the wiper to `host_data` on the next clock. Host writes to any other address and `conv_done` pulses leave the wiper unchanged.
- R4: In table mode, a `conv_done` pulse loads the wiper with `tbl_byte` with bit 7 cleared.
- R5: In offset mode, a `conv_done` pulse loads the wiper with `init_val` plus `tbl_byte`, where `tbl_byte` is read as signed two's complement. Sums below 0 give 00h and sums above 127 give 7Fh.
- R6: In the table modes, host writes to 00h do not change the wiper. A host write to 09h sets the wiper only while `manual_ovr`=1.
- R7: While `manual_ovr`=1 in the table modes, `conv_done` pulses do not change the wiper.
- R8: While `standby`=1, `conv_done` pulses do not change the wiper. The first `conv_done` pulse after `standby` clears loads it again.
- R9: In the table modes, the recalled initial value stays on the wiper until the first `conv_done` pulse after reset.
- R10: While reset is asserted, the wiper reads 40h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_update | input | 1 | 0 = direct mode, 1 = one of the table modes |
| mode_adder | input | 1 | In the table modes, 1 = offset mode |
| manual_ovr | input | 1 | Stops automatic loading and allows host writes to the wiper in the table modes |
| standby | input | 1 | Stops automatic loading |
| tbl_byte | input | 8 | Table entry selected for the current temperature |
| init_val | input | 8 | Initial-value register contents |
| host_we | input | 1 | Host write strobe, one cycle |
| host_addr | input | 8 | Host write address |
| host_data | input | 7 | Host write data |
| conv_done | input | 1 | Conversion-complete pulse |
| wiper | output | 7 | Wiper code |

## Verification
The hardest conditions to reach are the two saturation edges of the offset sum and the recall hold after a reset in table mode. The first needs a chosen pair of initial value and negative or large positive table byte. The second needs reset asserted while the mode bits already select a table mode, followed by a wait before any conversion pulse arrives. The stimulus drives both cases on purpose. It walks through direct, table, override, standby and offset phases, then resets inside table mode. A behavioural model is compared with the wiper on every cycle.

// File: rtl/wiper_update_ctrl.sv
module wiper_update_ctrl #(
  parameter int CODE_W = 7,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [CODE_W-1:0] RESET_CODE = 7'h40,
  parameter logic [ADDR_W-1:0] DIRECT_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] WIPER_ADDR = 8'h09
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_update,
  input  logic              mode_adder,
  input  logic              manual_ovr,
  input  logic              standby,
  input  logic [BYTE_W-1:0] tbl_byte,
  input  logic [BYTE_W-1:0] init_val,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [CODE_W-1:0] host_data,
  input  logic              conv_done,
  output logic [CODE_W-1:0] wiper
);
  localparam int SUM_W = BYTE_W + 2;
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic recall_pend;
  logic [CODE_W-1:0] init_code, offset_code, auto_code;
  logic signed [SUM_W-1:0] sum;
  logic direct_wr, table_wr, auto_ld;

  assign init_code = (init_val > BYTE_W'(CODE_MAX)) ? CODE_MAX : init_val[CODE_W-1:0];

  assign sum = $signed({2'b00, init_val}) + $signed({{2{tbl_byte[BYTE_W-1]}}, tbl_byte});

  always_comb begin
    if (sum < 0)                               offset_code = '0;
    else if (sum > $signed(SUM_W'(CODE_MAX)))  offset_code = CODE_MAX;
    else                                       offset_code = sum[CODE_W-1:0];
  end

  assign auto_code = mode_adder ? offset_code : tbl_byte[CODE_W-1:0];

  assign direct_wr = !mode_update && host_we && host_addr == DIRECT_ADDR;
  assign table_wr  = mode_update && manual_ovr && host_we && host_addr == WIPER_ADDR;
  assign auto_ld   = mode_update && !manual_ovr && !standby && conv_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wiper       <= RESET_CODE;
      recall_pend <= 1'b1;
    end else if (recall_pend) begin
      wiper       <= init_code;
      recall_pend <= 1'b0;
    end else if (direct_wr || table_wr) begin
      wiper <= host_data;
    end else if (auto_ld) begin
      wiper <= auto_code;
    end
  end

  AST_RECALL: assert property (@(posedge clk) disable iff (!rst_n) (recall_pend && !init_val[BYTE_W-1]) |=> wiper == $past(init_val[CODE_W-1:0])); // R2
  AST_DIRECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!recall_pend && !mode_update && !host_we) |=> $stable(wiper)); // R3
  AST_TABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (!recall_pend && mode_update && !mode_adder && conv_done && !manual_ovr && !standby && !host_we) |=> wiper == $past(tbl_byte[CODE_W-1:0])); // R4
  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!recall_pend && mode_update && manual_ovr && !host_we) |=> $stable(wiper)); // R7
  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!recall_pend && mode_update && standby && !host_we) |=> $stable(wiper)); // R8
  AST_TABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (!recall_pend && mode_update && manual_ovr && host_we && host_addr == WIPER_ADDR) |=> wiper == $past(host_data)); // R6
endmodule

// File: tb/tb_wiper_update_ctrl.sv
module tb_wiper_update_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic mode_update = 0, mode_adder = 0, manual_ovr = 0, standby = 0;
  logic [7:0] tbl_byte = 0, init_val = 8'h25;
  logic host_we = 0;
  logic [7:0] host_addr = 0;
  logic [6:0] host_data = 0;
  logic conv_done = 0;
  logic [6:0] wiper;

  int tests = 0, fails = 0;
  int m_w = 64;
  bit m_pend = 1;
  bit started = 0;
  string cur_req = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_update_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_update(mode_update), .mode_adder(mode_adder),
    .manual_ovr(manual_ovr), .standby(standby), .tbl_byte(tbl_byte), .init_val(init_val),
    .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
    .conv_done(conv_done), .wiper(wiper)
  );

  // behavioural reference model
  always @(posedge clk) begin
    int s;
    if (!rst_n) begin
      m_w = 64; m_pend = 1;
    end else if (m_pend) begin
      m_w = (init_val > 127) ? 127 : int'(init_val);
      m_pend = 0;
    end else if (!mode_update) begin
      if (host_we && host_addr == 0) m_w = int'(host_data);
    end else if (host_we && host_addr == 9 && manual_ovr) begin
      m_w = int'(host_data);
    end else if (conv_done && !manual_ovr && !standby) begin
      if (!mode_adder) m_w = int'(tbl_byte) % 128;
      else begin
        s = int'(init_val) + ((tbl_byte >= 128) ? int'(tbl_byte) - 256 : int'(tbl_byte));
        m_w = (s < 0) ? 0 : (s > 127) ? 127 : s;
      end
    end
  end

  always @(negedge clk) if (started) begin
    tests++;
    if (int'(wiper) != m_w) begin
      fails++;
      $display("FAIL %s model compare: actual %0h expected %0h", cur_req, wiper, m_w);
    end
  end

  task automatic check(string req, int exp);
    tests++;
    if (int'(wiper) != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, wiper, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [6:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_data = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic conv(logic [7:0] t);
    @(negedge clk); conv_done = 1; tbl_byte = t;
    @(negedge clk); conv_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    started = 1;
    repeat (2) @(negedge clk);
    check("R10", 8'h40);
    rst_n = 1; cur_req = "R2";
    @(negedge clk);
    check("R2", 8'h25);

    cur_req = "R3";
    wr(8'h00, 7'h0A);  check("R3", 8'h0A);
    wr(8'h09, 7'h11);  check("R3", 8'h0A);
    conv(8'h55);       check("R3", 8'h0A);
    cur_req = "R1"; mode_adder = 1;
    conv(8'h05);       check("R1", 8'h0A);
    wr(8'h00, 7'h0B);  check("R1", 8'h0B);
    mode_adder = 0; mode_update = 1;

    cur_req = "R4";
    conv(8'hC3);       check("R4", 8'h43);
    cur_req = "R6";
    wr(8'h00, 7'h12);  check("R6", 8'h43);
    wr(8'h09, 7'h12);  check("R6", 8'h43);
    manual_ovr = 1; cur_req = "R7";
    conv(8'h11);       check("R7", 8'h43);
    cur_req = "R6";
    wr(8'h09, 7'h22);  check("R6", 8'h22);
    manual_ovr = 0;

    standby = 1; cur_req = "R8";
    conv(8'h33);       check("R8", 8'h22);
    standby = 0;
    conv(8'h33);       check("R8", 8'h33);

    mode_adder = 1; cur_req = "R5";
    init_val = 8'h40; conv(8'hFE); check("R5", 8'h3E);
    init_val = 8'h10; conv(8'hE0); check("R5", 8'h00);
    init_val = 8'h70; conv(8'h20); check("R5", 8'h7F);
    init_val = 8'h7F; conv(8'h80); check("R5", 8'h00);
    init_val = 8'h20; conv(8'h05); check("R5", 8'h25);

    mode_adder = 0; cur_req = "R9";
    @(negedge clk); rst_n = 0; init_val = 8'h15;
    @(negedge clk); check("R10", 8'h40);
    rst_n = 1;
    @(negedge clk); check("R9", 8'h15);
    repeat (5) @(negedge clk);
    check("R9", 8'h15);
    conv(8'h6A);       check("R9", 8'h6A);

    cur_req = "R2";
    @(negedge clk); rst_n = 0; init_val = 8'h9C;
    @(negedge clk); rst_n = 1;
    @(negedge clk); check("R2", 8'h7F);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule